// File: doc/BRIEF.md
# Monitor Channel Handshake Slave

This block is the slave end of a byte-wide monitor channel carried in one slot of a time-division multiplexed frame. A one-cycle `frame_tick` marks each frame. On that tick the block samples the host's downstream byte and its two handshake bits. It updates its own upstream acknowledge bit, transmit-handshake bit and data byte, and these stay stable until the next tick. Frame alignment and bit serialization are handled outside the block.

The host opens a transfer with a command byte and a start address. It then streams data bytes for a write, or collects bytes for a read. The block turns these into single-cycle strobes on a register port and advances the address after every access. A byte only counts once it has been seen twice in a row. The host ends a transfer by leaving both of its handshake bits inactive for two frames. The block refuses a transfer by withholding its acknowledge bit. It does this on a malformed command, an out-of-range address, a lost byte or a collision on the data it drives.

All handshake bits are active high in this block. The host keeps its transmit bit active for as long as it is collecting read data.

Top module: `mon_slave`

## Requirements
- R1: After reset, `up_mr`, `up_mx`, `up_data`, `reg_wr` and `reg_rd` are all 0 and the block waits for a command byte.
- R2: A downstream byte is accepted only when `dn_mx` is 1 in two consecutive frames and both frames carry the same byte. `up_mr` stays 0 after a single copy or after two differing copies. It becomes 1 after the frame that completes the pair and stays 1 until a frame with `dn_mx` at 0.
- R3: If `dn_mx` is 0 in the frame after a first copy has been seen, before a matching second copy arrives, the transfer is aborted.
- R4: A frame with `dn_mx` = 0 and `dn_mr` = 0 that follows another such frame is end-of-message. It returns the block to idle from any state with no register access, including when the command or address is still missing.
- R5: While aborted, `up_mr` and `up_mx` stay 0 and no byte is acknowledged or accessed, however long `dn_mx` stays active. Only end-of-message (R4) leaves this state, so the abort always lasts at least two frames.
- R6: The first accepted byte is the command. 8'h80 means read and 8'h00 means write. Any other value aborts the transfer with no register access.
- R7: The second accepted byte is the start address. A value of 60 or above aborts the transfer with no register access.
- R8: In a write, each further accepted byte is written to the current address with one `reg_wr` strobe, and then the address increments. A byte that would land at address 60 or above is not written and aborts the transfer. Writes made earlier in the same transfer keep their values.
- R9: In a read, `up_mx` = 1 and `up_data` carries the register contents. The byte is held until the host sets `dn_mr` = 1 in a frame that is not the first frame of that byte. The block then drives `up_mx` = 0 for one frame and increments the address. If the new address is 60 or above, it aborts instead of sending.
- R10: During the address or write phase, `dn_mx` = 0 with `dn_mr` = 1 in two consecutive frames means no data byte arrived, and the transfer is aborted.
- R11: If, in a frame where the block is sending read data, the sampled `bus_data` differs from `up_data`, the block aborts and drops `up_mx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse; downstream slot valid |
| dn_mx | input | 1 | Host transmit handshake, active high |
| dn_mr | input | 1 | Host acknowledge handshake, active high |
| dn_data | input | 8 | Downstream monitor byte |
| bus_data | input | 8 | Upstream byte as seen on the shared bus |
| up_mx | output | 1 | Block transmit handshake, active high |
| up_mr | output | 1 | Block acknowledge handshake, active high |
| up_data | output | 8 | Upstream monitor byte driven by the block |
| reg_addr | output | 6 | Register port address |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe; data expected on `reg_rdata` the next cycle |
| reg_rdata | input | 8 | Read data |

## Verification
Some properties are checked on every cycle. An acknowledge only rises on a frame that carried an active transmit bit. A lost byte never leaves the acknowledge set. No write strobe ever reaches an address of 60 or above. An aborted block drives both handshake bits inactive. A collision drops `up_mx` on the next cycle. The byte being sent stays stable while it is being sent. Other behaviours need the bench's frame-level scenarios, because they depend on sequences of frames and on register contents. These are the command and address decode, partial writes kept when a burst runs past the end, end-of-message before the address arrives, the early-acknowledge rule, and the read data itself.

// File: rtl/mon_pkg.sv
package mon_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WR,
    ST_FETCH,
    ST_LOAD,
    ST_SEND,
    ST_GAP,
    ST_ABORT
  } mon_state_e;

  typedef enum logic [1:0] {
    RX_FIRST,
    RX_SECOND,
    RX_HELD
  } rx_state_e;

endpackage

// File: rtl/mon_rx_dup.sv
module mon_rx_dup
  import mon_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          frame,
  input  logic          mx,
  input  logic [DW-1:0] data,
  output logic          ack,
  output logic          byte_ok,
  output logic          drop_err
);

  rx_state_e     st;
  logic [DW-1:0] held;

  assign byte_ok  = en && frame && (st == RX_SECOND) && mx && (data == held);
  assign drop_err = en && frame && (st == RX_SECOND) && !mx;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st   <= RX_FIRST;
      held <= '0;
      ack  <= 1'b0;
    end else if (frame) begin
      case (st)
        RX_FIRST: begin
          if (mx) begin
            held <= data;
            st   <= RX_SECOND;
          end
        end
        RX_SECOND: begin
          if (!mx) begin
            st <= RX_FIRST;
          end else if (data == held) begin
            st  <= RX_HELD;
            ack <= 1'b1;
          end else begin
            held <= data;
          end
        end
        RX_HELD: begin
          if (!mx) begin
            st  <= RX_FIRST;
            ack <= 1'b0;
          end
        end
        default: st <= RX_FIRST;
      endcase
    end
  end

  // R2: acknowledge only rises on a frame whose transmit bit was active
  a_r2_ack_on_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(frame && mx));

  // R3: a lost second copy never leaves the acknowledge set
  a_r3_drop_no_ack: assert property (@(posedge clk) disable iff (rst)
    drop_err |=> !ack);

endmodule

// File: rtl/mon_frame_hold.sv
module mon_frame_hold #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic frame,
  input  logic cond,
  output logic hit
);

  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  assign hit = frame && cond && (cnt >= CW'(HOLD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (frame) begin
      if (!cond) cnt <= '0;
      else if (cnt < CW'(HOLD)) cnt <= cnt + 1'b1;
    end
  end

  // R4: the run counter saturates at its limit
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= HOLD);

endmodule

// File: rtl/mon_slave.sv
module mon_slave
  import mon_pkg::*;
#(
  parameter int DW         = 8,
  parameter int NUM_REGS   = 60,
  parameter int AW         = $clog2(NUM_REGS),
  parameter int END_FRAMES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_tick,
  input  logic          dn_mx,
  input  logic          dn_mr,
  input  logic [DW-1:0] dn_data,
  input  logic [DW-1:0] bus_data,
  output logic          up_mx,
  output logic          up_mr,
  output logic [DW-1:0] up_data,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);

  localparam logic [DW-1:0] CMD_RD = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] CMD_WR = '0;
  localparam logic [DW-1:0] LIMIT  = DW'(NUM_REGS);

  mon_state_e    state;
  logic [DW-1:0] addr_q;
  logic [DW-1:0] tx_q;
  logic          is_rd;
  logic          sent_q;
  logic          addr_ack_q;
  logic          up_mx_q;

  logic rx_en, rx_ack, byte_ok, drop_err;
  logic eom_hit, nodata_hit, nodata_abort;

  assign rx_en = (state == ST_IDLE) || (state == ST_ADDR) || (state == ST_WR);

  mon_rx_dup #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .en       (rx_en),
    .frame    (frame_tick),
    .mx       (dn_mx),
    .data     (dn_data),
    .ack      (rx_ack),
    .byte_ok  (byte_ok),
    .drop_err (drop_err)
  );

  mon_frame_hold #(.HOLD(END_FRAMES)) u_eom (
    .clk   (clk),
    .rst   (rst),
    .frame (frame_tick),
    .cond  (!dn_mx && !dn_mr),
    .hit   (eom_hit)
  );

  mon_frame_hold #(.HOLD(END_FRAMES)) u_nodata (
    .clk   (clk),
    .rst   (rst),
    .frame (frame_tick),
    .cond  (!dn_mx && dn_mr),
    .hit   (nodata_hit)
  );

  assign nodata_abort = nodata_hit && ((state == ST_ADDR) || (state == ST_WR));

  assign up_mr   = (rx_ack && rx_en) || addr_ack_q;
  assign up_mx   = up_mx_q;
  assign up_data = tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      tx_q       <= '0;
      is_rd      <= 1'b0;
      sent_q     <= 1'b0;
      addr_ack_q <= 1'b0;
      up_mx_q    <= 1'b0;
      reg_addr   <= '0;
      reg_wr     <= 1'b0;
      reg_wdata  <= '0;
      reg_rd     <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (frame_tick) addr_ack_q <= 1'b0;

      if (eom_hit) begin
        state   <= ST_IDLE;
        up_mx_q <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (drop_err) begin
              state <= ST_ABORT;
            end else if (byte_ok) begin
              if (dn_data == CMD_RD) begin
                is_rd <= 1'b1;
                state <= ST_ADDR;
              end else if (dn_data == CMD_WR) begin
                is_rd <= 1'b0;
                state <= ST_ADDR;
              end else begin
                state <= ST_ABORT;
              end
            end
          end
          ST_ADDR: begin
            if (nodata_abort || drop_err) begin
              state <= ST_ABORT;
            end else if (byte_ok) begin
              if (dn_data >= LIMIT) begin
                state <= ST_ABORT;
              end else if (is_rd) begin
                addr_q     <= dn_data;
                reg_addr   <= dn_data[AW-1:0];
                reg_rd     <= 1'b1;
                addr_ack_q <= 1'b1;
                state      <= ST_FETCH;
              end else begin
                addr_q <= dn_data;
                state  <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (nodata_abort || drop_err) begin
              state <= ST_ABORT;
            end else if (byte_ok) begin
              if (addr_q < LIMIT) begin
                reg_addr  <= addr_q[AW-1:0];
                reg_wdata <= dn_data;
                reg_wr    <= 1'b1;
                addr_q    <= addr_q + 1'b1;
              end else begin
                state <= ST_ABORT;
              end
            end
          end
          ST_FETCH: state <= ST_LOAD;
          ST_LOAD: begin
            tx_q    <= reg_rdata;
            up_mx_q <= 1'b1;
            sent_q  <= 1'b0;
            state   <= ST_SEND;
          end
          ST_SEND: begin
            if (frame_tick) begin
              if (bus_data != tx_q) begin
                up_mx_q <= 1'b0;
                state   <= ST_ABORT;
              end else if (dn_mr && sent_q) begin
                up_mx_q <= 1'b0;
                addr_q  <= addr_q + 1'b1;
                state   <= ST_GAP;
              end else begin
                sent_q <= 1'b1;
              end
            end
          end
          ST_GAP: begin
            if (frame_tick) begin
              if (addr_q < LIMIT) begin
                reg_addr <= addr_q[AW-1:0];
                reg_rd   <= 1'b1;
                state    <= ST_FETCH;
              end else begin
                state <= ST_ABORT;
              end
            end
          end
          default: state <= ST_ABORT;
        endcase
      end
    end
  end

  // R8: no write strobe reaches an out-of-range register
  a_r8_wr_in_range: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> (int'(reg_addr) < NUM_REGS));

  // R9: read and write strobes never coincide
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  // R5: an aborted block keeps both handshake bits inactive
  a_r5_abort_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ABORT) |-> (!up_mr && !up_mx));

  // R9: the byte on offer does not change while it is being sent
  a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SEND) && ($past(state) == ST_SEND)) |-> $stable(up_data));

  // R11: a collision while sending drops the transmit bit
  a_r11_collision: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SEND) && frame_tick && (bus_data != up_data)) |=> !up_mx);

  // R2: the acknowledge bit only rises on a frame
  a_r2_mr_on_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(up_mr) |-> $past(frame_tick));

endmodule

// File: tb/mon_slave_tb.sv
module mon_slave_tb;

  localparam int NREG = 60;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_tick = 1'b0;
  logic       dn_mx = 1'b0, dn_mr = 1'b0;
  logic [7:0] dn_data = '0, bus_data = '0;
  logic       up_mx, up_mr;
  logic [7:0] up_data;
  logic [5:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;

  int n_chk = 0, n_fail = 0, wr_cnt = 0, bad_wr = 0;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];

  always #4 clk = ~clk;

  mon_slave u_dut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .dn_mx(dn_mx), .dn_mr(dn_mr),
    .dn_data(dn_data), .bus_data(bus_data), .up_mx(up_mx), .up_mr(up_mr),
    .up_data(up_data), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] pattern(input int i);
    return 8'((i * 37 + 11) & 8'hff);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= pattern(i);
      reg_rdata <= '0;
    end else begin
      if (reg_rd) reg_rdata <= mem[reg_addr];
      if (reg_wr) begin
        wr_cnt <= wr_cnt + 1;
        if (int'(reg_addr) < NREG) mem[reg_addr] <= reg_wdata;
        else bad_wr <= bad_wr + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic mx, input logic mr, input logic [7:0] d, input bit collide);
    @(negedge clk);
    dn_mx = mx; dn_mr = mr; dn_data = d;
    bus_data = collide ? ~up_data : up_data;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit gap, input string req);
    frame(1'b1, 1'b0, b, 1'b0);
    chk(up_mr == 1'b0, "R2", up_mr, 0);
    frame(1'b1, 1'b0, b, 1'b0);
    chk(up_mr == exp_ack, req, up_mr, exp_ack);
    if (gap) frame(1'b0, 1'b0, b, 1'b0);
  endtask

  task automatic eom();
    frame(1'b0, 1'b0, 8'h00, 1'b0);
    frame(1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic read_byte(input logic [7:0] exp, input string req);
    frame(1'b1, 1'b0, 8'h00, 1'b0);
    chk(up_mx == 1'b1 && up_data == exp, req, {up_mx, up_data}, {1'b1, exp});
    frame(1'b1, 1'b1, 8'h00, 1'b0);
    chk(up_mx == 1'b0, req, up_mx, 0);
    frame(1'b1, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) exp_mem[i] = pattern(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(!up_mr && !up_mx && up_data == 8'h00 && !reg_wr && !reg_rd, "R1",
        {up_mr, up_mx, up_data}, 0);

    // R2: differing copies are not acknowledged, matching pair is
    frame(1'b1, 1'b0, 8'h80, 1'b0);
    frame(1'b1, 1'b0, 8'h00, 1'b0);
    chk(up_mr == 1'b0, "R2", up_mr, 0);
    frame(1'b1, 1'b0, 8'h00, 1'b0);
    chk(up_mr == 1'b1, "R2", up_mr, 1);
    frame(1'b1, 1'b0, 8'h00, 1'b0);
    chk(up_mr == 1'b1, "R2", up_mr, 1);
    frame(1'b0, 1'b0, 8'h00, 1'b0);
    chk(up_mr == 1'b0, "R2", up_mr, 0);
    send_byte(8'd5, 1'b1, 1'b1, "R7");
    send_byte(8'hC3, 1'b1, 1'b1, "R8");
    exp_mem[5] = 8'hC3;
    eom();
    chk(mem[5] == 8'hC3, "R8", mem[5], 8'hC3);

    // R8 / R9: random write bursts then read-back bursts
    for (int t = 0; t < 12; t++) begin
      int a, len;
      a   = int'($urandom % 50);
      len = 1 + int'($urandom % 5);
      send_byte(8'h00, 1'b1, 1'b1, "R6");
      send_byte(8'(a), 1'b1, 1'b1, "R7");
      for (int k = 0; k < len; k++) begin
        logic [7:0] v;
        v = 8'($urandom);
        send_byte(v, 1'b1, 1'b1, "R8");
        exp_mem[a + k] = v;
      end
      eom();
      for (int k = 0; k < len; k++)
        chk(mem[a + k] == exp_mem[a + k], "R8", mem[a + k], exp_mem[a + k]);
      send_byte(8'h80, 1'b1, 1'b1, "R6");
      send_byte(8'(a), 1'b1, 1'b1, "R7");
      for (int k = 0; k < len; k++) read_byte(exp_mem[a + k], "R9");
      eom();
    end

    // R8: burst running past the last register keeps earlier writes
    w0 = wr_cnt;
    send_byte(8'h00, 1'b1, 1'b1, "R6");
    send_byte(8'd58, 1'b1, 1'b1, "R7");
    send_byte(8'h11, 1'b1, 1'b1, "R8");
    send_byte(8'h22, 1'b1, 1'b1, "R8");
    send_byte(8'h33, 1'b0, 1'b1, "R8");
    exp_mem[58] = 8'h11; exp_mem[59] = 8'h22;
    send_byte(8'h44, 1'b0, 1'b1, "R5");
    eom();
    chk(mem[58] == 8'h11 && mem[59] == 8'h22, "R8", {mem[58], mem[59]}, 16'h1122);
    chk(wr_cnt == w0 + 2 && bad_wr == 0, "R8", wr_cnt - w0, 2);

    // R6: invalid command aborts with no access
    w0 = wr_cnt;
    send_byte(8'h81, 1'b0, 1'b1, "R6");
    send_byte(8'h00, 1'b0, 1'b1, "R5");
    eom();
    chk(wr_cnt == w0, "R6", wr_cnt - w0, 0);

    // R7: out-of-range start address
    send_byte(8'h00, 1'b1, 1'b1, "R6");
    send_byte(8'd60, 1'b0, 1'b1, "R7");
    send_byte(8'hAA, 1'b0, 1'b1, "R7");
    eom();
    chk(wr_cnt == w0, "R7", wr_cnt - w0, 0);

    // R4: end-of-message before the address returns to idle
    send_byte(8'h00, 1'b1, 1'b1, "R6");
    eom();
    send_byte(8'h80, 1'b1, 1'b1, "R4");
    send_byte(8'd3, 1'b1, 1'b1, "R7");
    read_byte(exp_mem[3], "R4");
    eom();
    chk(wr_cnt == w0, "R4", wr_cnt - w0, 0);

    // R3: transmit bit dropped before the second copy
    send_byte(8'h00, 1'b1, 1'b1, "R6");
    frame(1'b1, 1'b0, 8'h11, 1'b0);
    frame(1'b0, 1'b0, 8'h11, 1'b0);
    send_byte(8'h22, 1'b0, 1'b1, "R3");
    eom();
    chk(wr_cnt == w0, "R3", wr_cnt - w0, 0);

    // R10: no data byte for two frames while host holds MR
    send_byte(8'h00, 1'b1, 1'b1, "R6");
    send_byte(8'd10, 1'b1, 1'b1, "R7");
    frame(1'b0, 1'b1, 8'h00, 1'b0);
    frame(1'b0, 1'b1, 8'h00, 1'b0);
    send_byte(8'h5A, 1'b0, 1'b1, "R10");
    eom();
    chk(wr_cnt == w0, "R10", wr_cnt - w0, 0);

    // R11: collision on the byte being sent
    send_byte(8'h80, 1'b1, 1'b1, "R6");
    send_byte(8'd20, 1'b1, 1'b1, "R7");
    frame(1'b1, 1'b0, 8'h00, 1'b1);
    chk(up_mx == 1'b0, "R11", up_mx, 0);
    frame(1'b1, 1'b1, 8'h00, 1'b0);
    chk(up_mx == 1'b0 && up_mr == 1'b0, "R5", {up_mx, up_mr}, 0);
    eom();

    // R9: acknowledge in the first frame of a byte is ignored
    send_byte(8'h80, 1'b1, 1'b1, "R6");
    send_byte(8'd7, 1'b1, 1'b0, "R7");
    frame(1'b1, 1'b1, 8'h00, 1'b0);
    chk(up_mx == 1'b1 && up_data == exp_mem[7], "R9", {up_mx, up_data}, {1'b1, exp_mem[7]});
    frame(1'b1, 1'b1, 8'h00, 1'b0);
    chk(up_mx == 1'b0, "R9", up_mx, 0);
    frame(1'b1, 1'b0, 8'h00, 1'b0);
    chk(up_mx == 1'b1 && up_data == exp_mem[8], "R9", {up_mx, up_data}, {1'b1, exp_mem[8]});
    eom();

    // R9: read burst stops at the last register
    send_byte(8'h80, 1'b1, 1'b1, "R6");
    send_byte(8'd58, 1'b1, 1'b1, "R7");
    read_byte(exp_mem[58], "R9");
    read_byte(exp_mem[59], "R9");
    chk(up_mx == 1'b0, "R9", up_mx, 0);
    frame(1'b1, 1'b0, 8'h00, 1'b0);
    chk(up_mx == 1'b0 && up_mr == 1'b0, "R9", {up_mx, up_mr}, 0);
    eom();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule